// File: doc/BRIEF.md
# UART Interrupt Cause and Status Word

This block is the status and interrupt-cause word of a FIFO-based UART. It collects five interrupt causes (line status, receive data available, character timeout, transmit space available and modem status) and keeps each one pending until software acknowledges it. The same 32-bit word also carries the modem status byte, the line status byte and a 10-bit receive fill count. One read therefore returns every pending cause together with the state that explains it.

Software acknowledges causes by writing a byte to the status offset. Each ID bit written as one clears that cause. A separate configuration word holds four enable bits. The interrupt output is driven while any pending cause has its enable set. The serial shifters, the FIFOs and the baud timing are outside this block. They reach it only as single-cycle event inputs and level inputs.

Top module: `uart_irq_status_reg`

## Requirements
- R1: After reset, the status word reads as zero except for the live fill-count bits. The configuration word reads zero and `irq` is low.
- R2: An event input that is high at a clock edge sets its ID bit in the status word, and the bit reads as one from that edge on. The ID bits are: bit 0 line status, bit 1 receive data available, bit 2 character timeout, bit 3 transmit space available, bit 4 modem status. A pending bit stays set until it is acknowledged.
- R3: A write to the status offset with byte lane 0 enabled clears every ID bit whose bit in `bus_wdata[4:0]` is one. ID bits written as zero keep their value. Written bits 7:5 have no effect, and writes that do not enable byte lane 0 change nothing.
- R4: If a cause's event arrives in the same cycle as the acknowledge of that cause, the cause stays pending. This also applies to the modem change flags and to the sticky line error flags.
- R5: `irq` is high exactly when some pending cause has its enable set. Configuration bit 0 enables both receive data available and character timeout. Bit 1 enables transmit space, bit 2 enables line status and bit 3 enables modem status.
- R6: Status bits 15:12 show the CTS, DSR, RI and DCD levels sampled at the last edge (`modem_lvl[3:0]` in that order). Bits 11:8 are change flags. A flag sets when its input differs from the previous sample, and any change sets the modem status cause. Acknowledging ID bit 4 clears the change flags.
- R7: Status bits 23:16 are the line status byte. Bit 16 is data ready, bit 21 is transmit holding empty and bit 22 is transmitter empty; these are sampled levels. Overrun (bit 17), parity (bit 18), framing (bit 19), break (bit 20) and receive FIFO error (bit 23) are sticky. Any of these error events sets the line status cause. Acknowledging ID bit 0 clears the sticky error flags.
- R8: The fill count appears without delay. Count bits 7:0 are at status bits 31:24, count bits 9:8 are at status bits 7:6, and status bit 5 reads zero.
- R9: Causes whose events arrive in the same cycle are all pending together and are returned by a single read.
- R10: A write to the configuration offset with byte lane 0 enabled stores `bus_wdata[3:0]` as the enables, and the enables read back in bits 3:0. Read data depends only on `bus_addr`. An address that is neither offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from `bus_addr`) |
| ev_rx_avail | input | 1 | Receive data available event |
| ev_char_tmo | input | 1 | Character timeout event |
| ev_tx_space | input | 1 | Transmit space available event |
| ev_overrun | input | 1 | Overrun error event |
| ev_parity | input | 1 | Parity error event |
| ev_framing | input | 1 | Framing error event |
| ev_break | input | 1 | Break detected event |
| ev_fifo_err | input | 1 | Receive FIFO error event |
| lv_data_ready | input | 1 | Data ready level |
| lv_thr_empty | input | 1 | Transmit holding empty level |
| lv_tx_empty | input | 1 | Transmitter empty level |
| modem_lvl | input | 4 | CTS, DSR, RI and DCD levels (bits 0 to 3) |
| rx_fill | input | 10 | Receive FIFO fill count |
| irq | output | 1 | Interrupt request |

## Verification
The stored results lag their cause by one edge. Every ID bit, change flag, sampled level, sticky error and enable reflects the inputs at the most recent rising edge. The fill count and `irq` follow the stored state with no delay, so `irq` changes in the same cycle as the pending bits it depends on. The bench applies inputs just after a falling edge and advances a behavioural model at each rising edge. At every falling edge it compares each field of the word and `irq` against that model, so each result is sampled exactly one edge after its stimulus.

// File: rtl/uis_pkg.sv
package uis_pkg;
  localparam int CAUSE_N   = 5;
  localparam int C_LINE    = 0;
  localparam int C_RDA     = 1;
  localparam int C_CTI     = 2;
  localparam int C_TSA     = 3;
  localparam int C_MST     = 4;
  localparam int MODEM_N   = 4;
  localparam int LERR_N    = 5;
  localparam int FILL_W    = 10;
  localparam int EN_W      = 4;

  // Pack the four status groups into one word; fill count is split.
  function automatic logic [31:0] pack_status(input logic [CAUSE_N-1:0] id,
                                              input logic [7:0] msr,
                                              input logic [7:0] lsr,
                                              input logic [FILL_W-1:0] fill);
    return {fill[7:0], lsr, msr, fill[9:8], 1'b0, id};
  endfunction

  // Map the four configuration enables onto the five cause bits.
  function automatic logic [CAUSE_N-1:0] expand_enables(input logic [EN_W-1:0] en);
    logic [CAUSE_N-1:0] m;
    m[C_LINE] = en[2];
    m[C_RDA]  = en[0];
    m[C_CTI]  = en[0];
    m[C_TSA]  = en[1];
    m[C_MST]  = en[3];
    return m;
  endfunction
endpackage

// File: rtl/uis_cause_bank.sv
module uis_cause_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] ack,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_cause
    always_ff @(posedge clk) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= set_ev[i] | (pend[i] & ~ack[i]);
    end

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> pend[i]);
    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !set_ev[i]) |=> !pend[i]);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && !ack[i]) |=> pend[i]);
  end
endmodule

// File: rtl/uis_modem_track.sv
module uis_modem_track #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_in,
  input  logic         ack,
  output logic [W-1:0] lvl_q,
  output logic [W-1:0] delta,
  output logic         changed
);
  logic [W-1:0] chg;
  assign chg     = lvl_in ^ lvl_q;
  assign changed = |chg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
      delta <= '0;
    end else begin
      lvl_q <= lvl_in;
      delta <= chg | (delta & ~{W{ack}});
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    p_delta_on_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_in[i] != lvl_q[i]) |=> delta[i]);
    p_level_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (lvl_q[i] == $past(lvl_in[i])));
  end
endmodule

// File: rtl/uis_line_track.sv
module uis_line_track #(
  parameter int NERR = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NERR-1:0] err_ev,   // overrun, parity, framing, break, fifo error
  input  logic            lv_dr,
  input  logic            lv_thre,
  input  logic            lv_temt,
  input  logic            ack,
  output logic [7:0]      lsr,
  output logic            err_any
);
  logic [NERR-1:0] sticky;
  logic            dr_q, thre_q, temt_q;

  assign err_any = |err_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky <= '0;
      dr_q   <= 1'b0;
      thre_q <= 1'b0;
      temt_q <= 1'b0;
    end else begin
      sticky <= err_ev | (sticky & ~{NERR{ack}});
      dr_q   <= lv_dr;
      thre_q <= lv_thre;
      temt_q <= lv_temt;
    end
  end

  assign lsr = {sticky[4], temt_q, thre_q, sticky[3], sticky[2],
                sticky[1], sticky[0], dr_q};

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ev[1] && !$past(ack)) |=> lsr[2]);
  p_err_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !err_ev[0]) |=> !lsr[1]);
endmodule

// File: rtl/uart_irq_status_reg.sv
module uart_irq_status_reg
  import uis_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [11:0] STAT_ADDR = 12'h000,
  parameter logic [11:0] CFG_ADDR  = 12'h008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ev_rx_avail,
  input  logic              ev_char_tmo,
  input  logic              ev_tx_space,
  input  logic              ev_overrun,
  input  logic              ev_parity,
  input  logic              ev_framing,
  input  logic              ev_break,
  input  logic              ev_fifo_err,
  input  logic              lv_data_ready,
  input  logic              lv_thr_empty,
  input  logic              lv_tx_empty,
  input  logic [3:0]        modem_lvl,
  input  logic [9:0]        rx_fill,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_STAT = STAT_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_CFG  = CFG_ADDR[ADDR_W-1:0];

  // Named internal events
  logic               stat_hit, cfg_hit, wr_stat, wr_cfg;
  logic [CAUSE_N-1:0] ack_vec, set_vec, pend, en_map;
  logic [EN_W-1:0]    cfg_en;
  logic [MODEM_N-1:0] m_lvl, m_delta;
  logic               m_changed, l_err;
  logic [7:0]         lsr_byte;

  assign stat_hit = (bus_addr == A_STAT);
  assign cfg_hit  = (bus_addr == A_CFG);
  assign wr_stat  = bus_sel & bus_wr & bus_be[0] & stat_hit;
  assign wr_cfg   = bus_sel & bus_wr & bus_be[0] & cfg_hit;
  assign ack_vec  = wr_stat ? bus_wdata[CAUSE_N-1:0] : '0;

  uis_modem_track #(.W(MODEM_N)) u_modem (
    .clk(clk), .rst_n(rst_n), .lvl_in(modem_lvl), .ack(ack_vec[C_MST]),
    .lvl_q(m_lvl), .delta(m_delta), .changed(m_changed)
  );

  uis_line_track #(.NERR(LERR_N)) u_line (
    .clk(clk), .rst_n(rst_n),
    .err_ev({ev_fifo_err, ev_break, ev_framing, ev_parity, ev_overrun}),
    .lv_dr(lv_data_ready), .lv_thre(lv_thr_empty), .lv_temt(lv_tx_empty),
    .ack(ack_vec[C_LINE]), .lsr(lsr_byte), .err_any(l_err)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[C_LINE] = l_err;
    set_vec[C_RDA]  = ev_rx_avail;
    set_vec[C_CTI]  = ev_char_tmo;
    set_vec[C_TSA]  = ev_tx_space;
    set_vec[C_MST]  = m_changed;
  end

  uis_cause_bank #(.N(CAUSE_N)) u_causes (
    .clk(clk), .rst_n(rst_n), .set_ev(set_vec), .ack(ack_vec), .pend(pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_en <= '0;
    else if (wr_cfg) cfg_en <= bus_wdata[EN_W-1:0];
  end

  assign en_map = expand_enables(cfg_en);
  assign irq    = |(pend & en_map);

  always_comb begin
    if (stat_hit)     bus_rdata = pack_status(pend, {m_lvl, m_delta}, lsr_byte, rx_fill);
    else if (cfg_hit) bus_rdata = {{(32-EN_W){1'b0}}, cfg_en};
    else              bus_rdata = '0;
  end

  p_no_enable_no_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en == '0) |-> !irq);
  p_cfg_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> (cfg_en == $past(bus_wdata[EN_W-1:0])));
  p_quiet_no_irq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !irq);
endmodule

// File: tb/uart_irq_status_reg_tb.sv
module uart_irq_status_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] STAT = 12'h000;
  localparam logic [11:0] CFG  = 12'h008;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = STAT;
  logic [3:0]  bus_be = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic ev_rx_avail = 0, ev_char_tmo = 0, ev_tx_space = 0;
  logic ev_overrun = 0, ev_parity = 0, ev_framing = 0, ev_break = 0, ev_fifo_err = 0;
  logic lv_data_ready = 0, lv_thr_empty = 0, lv_tx_empty = 0;
  logic [3:0] modem_lvl = 0;
  logic [9:0] rx_fill = 0;
  logic irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ev_rx_avail(ev_rx_avail), .ev_char_tmo(ev_char_tmo),
    .ev_tx_space(ev_tx_space), .ev_overrun(ev_overrun), .ev_parity(ev_parity),
    .ev_framing(ev_framing), .ev_break(ev_break), .ev_fifo_err(ev_fifo_err),
    .lv_data_ready(lv_data_ready), .lv_thr_empty(lv_thr_empty),
    .lv_tx_empty(lv_tx_empty), .modem_lvl(modem_lvl), .rx_fill(rx_fill), .irq(irq)
  );

  // Behavioural reference model
  logic [4:0] m_pend;
  logic [3:0] m_lvl, m_dlt, m_en;
  logic [4:0] m_err;
  logic m_dr, m_thr, m_tmt;
  logic [4:0] k_ack;
  logic [3:0] k_chg;
  logic [4:0] k_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_lvl = 0; m_dlt = 0; m_en = 0; m_err = 0;
      m_dr = 0; m_thr = 0; m_tmt = 0;
    end else begin
      k_ack = (bus_sel && bus_wr && bus_be[0] && bus_addr == STAT) ? bus_wdata[4:0] : 5'd0;
      k_chg = modem_lvl ^ m_lvl;
      k_err = {ev_fifo_err, ev_break, ev_framing, ev_parity, ev_overrun};
      for (int i = 0; i < 4; i++)
        if (k_chg[i]) m_dlt[i] = 1; else if (k_ack[4]) m_dlt[i] = 0;
      for (int i = 0; i < 5; i++)
        if (k_err[i]) m_err[i] = 1; else if (k_ack[0]) m_err[i] = 0;
      m_lvl = modem_lvl;
      m_dr = lv_data_ready; m_thr = lv_thr_empty; m_tmt = lv_tx_empty;
      if (k_err != 0) m_pend[0] = 1; else if (k_ack[0]) m_pend[0] = 0;
      if (ev_rx_avail) m_pend[1] = 1; else if (k_ack[1]) m_pend[1] = 0;
      if (ev_char_tmo) m_pend[2] = 1; else if (k_ack[2]) m_pend[2] = 0;
      if (ev_tx_space) m_pend[3] = 1; else if (k_ack[3]) m_pend[3] = 0;
      if (k_chg != 0) m_pend[4] = 1; else if (k_ack[4]) m_pend[4] = 0;
      if (bus_sel && bus_wr && bus_be[0] && bus_addr == CFG) m_en = bus_wdata[3:0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [7:0] el;
    logic exp_irq;
    el = 8'h00;
    el[0] = m_dr; el[1] = m_err[0]; el[2] = m_err[1]; el[3] = m_err[2];
    el[4] = m_err[3]; el[5] = m_thr; el[6] = m_tmt; el[7] = m_err[4];
    exp_irq = (m_pend[0] & m_en[2]) | ((m_pend[1] | m_pend[2]) & m_en[0]) |
              (m_pend[3] & m_en[1]) | (m_pend[4] & m_en[3]);
    if (bus_addr == STAT) begin
      chk("R2 id", {27'd0, bus_rdata[4:0]}, {27'd0, m_pend});
      chk("R6 modem", {24'd0, bus_rdata[15:8]}, {24'd0, m_lvl, m_dlt});
      chk("R7 line", {24'd0, bus_rdata[23:16]}, {24'd0, el});
      chk("R8 fill", {22'd0, bus_rdata[31:24], bus_rdata[7:6]},
          {22'd0, rx_fill[7:0], rx_fill[9:8]});
      chk("R8 bit5", {31'd0, bus_rdata[5]}, 32'd0);
    end
    chk("R5 irq", {31'd0, irq}, {31'd0, exp_irq});
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic bwrite(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    tick();
    bus_sel = 0; bus_wr = 0; bus_addr = STAT; bus_be = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tick(); tick();
    chk("R1 status", bus_rdata, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    bus_addr = CFG; tick();
    chk("R1 cfg", bus_rdata, 32'd0);
    bus_addr = STAT;
    rst_n = 1; tick();

    // R2 single cause
    ev_rx_avail = 1; tick(); ev_rx_avail = 0;
    chk("R2 rda", {27'd0, bus_rdata[4:0]}, 32'h02);
    tick();
    chk("R2 held", {27'd0, bus_rdata[4:0]}, 32'h02);
    bwrite(STAT, 32'h02, 4'b0001);

    // R9 simultaneous causes
    ev_tx_space = 1; ev_char_tmo = 1; tick(); ev_tx_space = 0; ev_char_tmo = 0;
    chk("R9 both", {27'd0, bus_rdata[4:0]}, 32'h0C);

    // R3 partial ack, bits 7:5 ignored
    rx_fill = 10'h3C5;
    bwrite(STAT, 32'hFFFF_FFC4, 4'b0001);
    chk("R3 partial", {27'd0, bus_rdata[4:0]}, 32'h08);
    chk("R8 split", {24'd0, bus_rdata[31:24]}, 32'hC5);
    chk("R8 hi", {30'd0, bus_rdata[7:6]}, 32'h3);
    bwrite(STAT, 32'hFFFF_FFFF, 4'b1110);
    chk("R3 lane ignored", {27'd0, bus_rdata[4:0]}, 32'h08);

    // R4 set wins
    ev_tx_space = 1; bwrite(STAT, 32'h08, 4'b0001); ev_tx_space = 0;
    chk("R4 set wins", {27'd0, bus_rdata[4:0]}, 32'h08);
    bwrite(STAT, 32'h08, 4'b0001);
    chk("R3 cleared", {27'd0, bus_rdata[4:0]}, 32'h00);

    // R10 and R5
    ev_rx_avail = 1; tick(); ev_rx_avail = 0;
    chk("R5 no enable", {31'd0, irq}, 32'd0);
    bwrite(CFG, 32'h0000_0001, 4'b0001);
    chk("R5 enabled", {31'd0, irq}, 32'd1);
    bus_addr = CFG; tick();
    chk("R10 readback", bus_rdata, 32'h1);
    bus_addr = 12'h010; tick();
    chk("R10 other addr", bus_rdata, 32'h0);
    bus_addr = STAT;
    bwrite(CFG, 32'h0000_000E, 4'b0001);
    chk("R5 rda masked", {31'd0, irq}, 32'd0);
    bwrite(STAT, 32'h1F, 4'b0001);

    // R6 modem
    modem_lvl = 4'b0101; tick();
    chk("R6 change", {24'd0, bus_rdata[15:8]}, 32'h55);
    chk("R6 cause", {31'd0, bus_rdata[4]}, 32'd1);
    chk("R6 irq", {31'd0, irq}, 32'd1);
    tick();
    chk("R6 sticky", {24'd0, bus_rdata[15:8]}, 32'h55);
    bwrite(STAT, 32'h10, 4'b0001);
    chk("R6 ack", {24'd0, bus_rdata[15:8]}, 32'h50);
    chk("R6 cause ack", {31'd0, bus_rdata[4]}, 32'd0);

    // R7 line
    ev_parity = 1; tick(); ev_parity = 0;
    chk("R7 parity", {24'd0, bus_rdata[23:16]}, 32'h04);
    chk("R7 cause", {31'd0, bus_rdata[0]}, 32'd1);
    lv_thr_empty = 1; ev_fifo_err = 1; bwrite(STAT, 32'h01, 4'b0001); ev_fifo_err = 0;
    chk("R7 fifo err wins", {24'd0, bus_rdata[23:16]}, 32'hA0);
    bwrite(STAT, 32'h01, 4'b0001);
    chk("R7 ack", {24'd0, bus_rdata[23:16]}, 32'h20);

    // Mixed traffic against the model
    for (int n = 0; n < 2000; n++) begin
      ev_rx_avail  = ($urandom_range(0, 7) == 0);
      ev_char_tmo  = ($urandom_range(0, 9) == 0);
      ev_tx_space  = ($urandom_range(0, 7) == 0);
      ev_overrun   = ($urandom_range(0, 15) == 0);
      ev_parity    = ($urandom_range(0, 15) == 0);
      ev_framing   = ($urandom_range(0, 15) == 0);
      ev_break     = ($urandom_range(0, 19) == 0);
      ev_fifo_err  = ($urandom_range(0, 19) == 0);
      lv_data_ready = $urandom_range(0, 1);
      lv_thr_empty  = $urandom_range(0, 1);
      lv_tx_empty   = $urandom_range(0, 1);
      if ($urandom_range(0, 5) == 0) modem_lvl = modem_lvl ^ 4'($urandom_range(1, 15));
      rx_fill = 10'($urandom_range(0, 1023));
      case ($urandom_range(0, 9))
        0, 1: bwrite(STAT, $urandom, 4'($urandom_range(0, 15)));
        2:    bwrite(CFG, $urandom, 4'($urandom_range(0, 15)));
        default: tick();
      endcase
    end
    ev_rx_avail = 0; ev_char_tmo = 0; ev_tx_space = 0; ev_overrun = 0;
    ev_parity = 0; ev_framing = 0; ev_break = 0; ev_fifo_err = 0;
    tick();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule